// File: doc/BRIEF.md
# Checkpointed Register File with Single-Cycle Rollback

This block holds speculative architectural state for a core that executes ahead of a known-good point. Each register is kept twice: a live copy that instructions read and write, and a saved copy that holds the last checkpoint. Ordinary writes touch only the live copy. When the surrounding pipeline decides that a run of work is good, it pulses `ckpt_commit`, and every live value is saved into its checkpoint copy on that clock edge. When the pipeline decides that the run must be abandoned, for example on an exception, it pulses `ckpt_restore`, and every live value is replaced by its checkpoint on that edge.

The file has 64 registers of 32 bits, two asynchronous read ports and one write port. Restore outranks commit, and a write presented together with a restore is dropped. Both operations therefore leave the whole file in one consistent state after one edge.

Top module: `ckpt_regfile`

## Requirements
- R1: While `rst_n` is low, both the live and the checkpoint copy of every register are cleared to zero, so reads return zero and a restore right after reset also gives zero everywhere.
- R2: When `wr_en` is 1 and `ckpt_restore` is 0, the live copy of register `wr_addr` takes `wr_data` at the clock edge. Both read ports return the live copy of the addressed register combinationally, including registers 0 and 63 and both ports reading the same address.
- R3: A write never changes any checkpoint copy. After writes with no commit, a restore brings back the values held before those writes.
- R4: When `ckpt_commit` is 1 and `ckpt_restore` is 0, every checkpoint copy takes the live value held before that edge, all in one cycle. A write in the same cycle updates only the live copy and is not part of the checkpoint.
- R5: When `ckpt_restore` is 1, every live copy takes its checkpoint value at that edge. A read in the following cycle returns the restored value.
- R6: When `ckpt_commit` and `ckpt_restore` are both 1, the restore is carried out and the commit is ignored, so the checkpoint copies keep their old values.
- R7: A write presented in the same cycle as a restore is discarded. Its target register holds its checkpoint value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 6 | Read port A register index |
| rd_data_a | output | 32 | Read port A live value |
| rd_addr_b | input | 6 | Read port B register index |
| rd_data_b | output | 32 | Read port B live value |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write register index |
| wr_data | input | 32 | Write value |
| ckpt_commit | input | 1 | Save all live values into the checkpoint |
| ckpt_restore | input | 1 | Reload all live values from the checkpoint |

## Verification
Each scenario ends by reading all 64 registers through both ports at once, with the two ports walking the file in opposite directions. This way a fault in one port or in the index decode shows up. The write data is a pattern that depends on the register index, so a value copied into the wrong register cannot pass as correct. The commit and restore tests overlap a write, or the other command, in the same cycle as the command. These cases separate the ordering rules: a write made during a commit is absent from the checkpoint, restore wins over commit, and a write made during a restore is dropped. A test that writes and then restores without any commit shows whether writes leak into the checkpoint copies.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef struct packed {
    logic save;     // checkpoint <= live for every register
    logic reload;   // live <= checkpoint for every register
    logic store;    // single-register write to the live copy
  } ckpt_evt_t;

  // Restore dominates commit and suppresses the write port.
  function automatic ckpt_evt_t ckpt_resolve(input logic commit,
                                             input logic restore,
                                             input logic wen);
    ckpt_evt_t e;
    e.reload = restore;
    e.save   = commit & ~restore;
    e.store  = wen & ~restore;
    return e;
  endfunction

endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int NREGS = 64,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             commit,
  input  logic             restore,
  input  logic             wen,
  input  logic [AW-1:0]    waddr,
  output ckpt_evt_t        evt,
  output logic [NREGS-1:0] wsel
);

  always_comb begin
    evt  = ckpt_resolve(commit, restore, wen);
    wsel = '0;
    for (int i = 0; i < NREGS; i++) begin
      wsel[i] = evt.store && (waddr == AW'(i));
    end
  end

endmodule

// File: rtl/ckpt_cell.sv
module ckpt_cell
  import ckpt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ckpt_evt_t        evt,
  input  logic             sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] live_q,
  output logic [WIDTH-1:0] saved_q
);

  function automatic logic [WIDTH-1:0] next_live(input logic [WIDTH-1:0] cur,
                                                 input logic [WIDTH-1:0] chk,
                                                 input logic             reload,
                                                 input logic             hit,
                                                 input logic [WIDTH-1:0] d);
    if (reload)   return chk;
    else if (hit) return d;
    else          return cur;
  endfunction

  function automatic logic [WIDTH-1:0] next_saved(input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] lv,
                                                  input logic             save);
    return save ? lv : cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      saved_q <= '0;
    end else begin
      live_q  <= next_live(live_q, saved_q, evt.reload, sel, wdata);
      saved_q <= next_saved(saved_q, live_q, evt.save);
    end
  end

endmodule

// File: rtl/ckpt_rdport.sv
module ckpt_rdport #(
  parameter int NREGS = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][WIDTH-1:0] file_q,
  input  logic [AW-1:0]               addr,
  output logic [WIDTH-1:0]            data
);

  assign data = file_q[addr];

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckpt_pkg::*;
#(
  parameter int NREGS = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ckpt_commit,
  input  logic             ckpt_restore
);

  // Named internal events, visible to the bound checker.
  ckpt_evt_t                    evt;
  logic [NREGS-1:0]             wsel;
  logic [NREGS-1:0][WIDTH-1:0]  live_q;
  logic [NREGS-1:0][WIDTH-1:0]  saved_q;
  logic                         save_fire;
  logic                         reload_fire;

  assign save_fire   = evt.save;
  assign reload_fire = evt.reload;

  ckpt_ctrl #(.NREGS(NREGS)) u_ctrl (
    .commit  (ckpt_commit),
    .restore (ckpt_restore),
    .wen     (wr_en),
    .waddr   (wr_addr),
    .evt     (evt),
    .wsel    (wsel)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    ckpt_cell #(.WIDTH(WIDTH)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .sel     (wsel[g]),
      .wdata   (wr_data),
      .live_q  (live_q[g]),
      .saved_q (saved_q[g])
    );
  end

  ckpt_rdport #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rd_a (
    .file_q (live_q),
    .addr   (rd_addr_a),
    .data   (rd_data_a)
  );

  ckpt_rdport #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rd_b (
    .file_q (live_q),
    .addr   (rd_addr_b),
    .data   (rd_data_b)
  );

endmodule

// File: rtl/ckpt_regfile_chk.sv
module ckpt_regfile_chk #(
  parameter int NREGS = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [AW-1:0]               wr_addr,
  input logic [WIDTH-1:0]            wr_data,
  input logic                        ckpt_commit,
  input logic                        ckpt_restore,
  input logic [AW-1:0]               rd_addr_a,
  input logic [WIDTH-1:0]            rd_data_a,
  input logic [NREGS-1:0][WIDTH-1:0] live_q,
  input logic [NREGS-1:0][WIDTH-1:0] saved_q,
  input logic                        save_fire
);

  // R1: a reset cycle leaves both copies cleared.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (live_q == '0 && saved_q == '0));

  // R2: an accepted write lands in the live copy of its target.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ckpt_restore) |=> live_q[$past(wr_addr)] == $past(wr_data));

  // R2: the read port presents the live copy.
  p_read_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_a == live_q[rd_addr_a]);

  // R3: without a commit the checkpoint copies do not move.
  p_saved_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !save_fire |=> $stable(saved_q));

  // R4: a commit saves the whole pre-edge live file.
  p_commit_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save_fire |=> saved_q == $past(live_q));

  // R5 and R7: a restore reloads every live copy, a concurrent write included.
  p_restore_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> live_q == $past(saved_q));

  // R6: restore wins over a simultaneous commit.
  p_restore_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_restore && ckpt_commit) |=> saved_q == $past(saved_q));

endmodule

bind ckpt_regfile ckpt_regfile_chk #(.NREGS(NREGS), .WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .ckpt_commit  (ckpt_commit),
  .ckpt_restore (ckpt_restore),
  .rd_addr_a    (rd_addr_a),
  .rd_data_a    (rd_data_a),
  .live_q       (live_q),
  .saved_q      (saved_q),
  .save_fire    (save_fire)
);

// File: tb/tb_ckpt_regfile.sv
`timescale 1ns/1ps
module tb_ckpt_regfile;

  localparam int N  = 64;
  localparam int W  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [W-1:0]  rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0, ckpt_commit = 1'b0, ckpt_restore = 1'b0;

  int checks = 0;
  int errors = 0;

  // Bench model of both copies.
  logic [W-1:0] m_live [N];
  logic [W-1:0] m_save [N];

  always #10 clk = ~clk;   // 50 MHz

  ckpt_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ckpt_commit(ckpt_commit), .ckpt_restore(ckpt_restore)
  );

  function automatic logic [W-1:0] pat(input int r, input int seed);
    return W'((r * 32'h01010101) ^ (seed * 32'h9E3779B1) ^ r);
  endfunction

  // One clock cycle of stimulus; the model follows the requirements.
  task automatic cycle(input logic we, input int wa, input logic [W-1:0] wd,
                       input logic cm, input logic rb);
    logic [W-1:0] old_live [N];
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    ckpt_commit = cm; ckpt_restore = rb;
    @(posedge clk);
    foreach (old_live[i]) old_live[i] = m_live[i];
    if (rb) begin
      foreach (m_live[i]) m_live[i] = m_save[i];
    end else begin
      if (cm) foreach (m_save[i]) m_save[i] = old_live[i];
      if (we) m_live[wa] = wd;
    end
    @(negedge clk);
    wr_en = 1'b0; ckpt_commit = 1'b0; ckpt_restore = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < N; r++) begin
      rd_addr_a = AW'(r);
      rd_addr_b = AW'(N - 1 - r);
      #1;
      checks++;
      if (rd_data_a !== m_live[r]) begin
        errors++;
        $display("FAIL %s port A reg %0d: got %h expected %h", tag, r, rd_data_a, m_live[r]);
      end
      checks++;
      if (rd_data_b !== m_live[N-1-r]) begin
        errors++;
        $display("FAIL %s port B reg %0d: got %h expected %h", tag, N-1-r, rd_data_b, m_live[N-1-r]);
      end
    end
  endtask

  task automatic write_all(input int seed);
    for (int r = 0; r < N; r++) cycle(1'b1, r, pat(r, seed), 1'b0, 1'b0);
  endtask

  task automatic t_reset;        // R1
    check_all("R1 after reset");
    cycle(1'b0, 0, '0, 1'b0, 1'b1);
    check_all("R1 restore after reset");
  endtask

  task automatic t_write_read;   // R2
    write_all(1);
    check_all("R2 write all");
    cycle(1'b1, 63, 32'hFFFF_0063, 1'b0, 1'b0);
    cycle(1'b1, 0,  32'hA5A5_0000, 1'b0, 1'b0);
    rd_addr_a = 6'd63; rd_addr_b = 6'd63; #1;
    checks++;
    if (rd_data_a !== rd_data_b || rd_data_a !== 32'hFFFF_0063) begin
      errors++;
      $display("FAIL R2 same address: got %h/%h expected %h", rd_data_a, rd_data_b, 32'hFFFF_0063);
    end
    check_all("R2 boundary regs");
  endtask

  task automatic t_no_leak;      // R3: checkpoint still all zero
    cycle(1'b0, 0, '0, 1'b0, 1'b1);
    check_all("R3 writes not in checkpoint");
  endtask

  task automatic t_commit;       // R4
    write_all(2);
    cycle(1'b1, 5, 32'hDEAD_0005, 1'b1, 1'b0);   // write concurrent with commit
    check_all("R4 after commit");
    write_all(3);
    cycle(1'b0, 0, '0, 1'b0, 1'b1);
    check_all("R4 checkpoint content");
  endtask

  task automatic t_restore;      // R5
    write_all(4);
    cycle(1'b1, 9, 32'h1234_5678, 1'b1, 1'b0);
    write_all(5);
    cycle(1'b0, 0, '0, 1'b0, 1'b1);
    check_all("R5 restore next cycle");
  endtask

  task automatic t_both;         // R6
    write_all(6);
    cycle(1'b0, 0, '0, 1'b1, 1'b1);
    check_all("R6 both asserted");
    write_all(7);
    cycle(1'b0, 0, '0, 1'b0, 1'b1);
    check_all("R6 checkpoint kept");
  endtask

  task automatic t_write_in_restore; // R7
    write_all(8);
    cycle(1'b1, 17, 32'hBAD0_0017, 1'b0, 1'b1);
    check_all("R7 write dropped");
  endtask

  initial begin
    foreach (m_live[i]) begin m_live[i] = '0; m_save[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_no_leak();
    t_commit();
    t_restore();
    t_both();
    t_write_in_restore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule